// File: doc/BRIEF.md
# DRAM Refresh Pacing Timer

This block tells a DRAM command scheduler when to issue auto-refresh commands. It reads the controller clock frequency in MHz and works out how many clock cycles fit into one refresh slot. The memory needs 8192 refreshes in every 64 ms window, which is one refresh at least every 7.8125 µs. The slot length is therefore `floor(mhz * 125 / 16)` cycles. At 400 MHz that comes to 3125 cycles.

A free-running down-counter measures these slots. Each time the counter expires, the refreshes owed for that slot go into a small postponement counter. The block asks for refreshes one at a time on a request/grant handshake. In single mode every slot owes one refresh. In burst mode the slot is eight times longer and owes eight refreshes, which the scheduler can then issue back to back.

The enable bit and the burst bit are taken into account only when the counter reloads. A slot that is in progress is therefore never cut short or changed part way.

Top module: `refresh_pacer`

## Requirements
- R1: In single mode, consecutive slot expiries are `max(1, floor(clk_mhz*125/16))` clock cycles apart (3125 cycles at 400 MHz).
- R2: In burst mode the slot length is eight times the single-mode slot, and each expiry owes exactly eight refreshes. With the grant held high, these appear as eight consecutive request cycles.
- R3: In single mode each expiry owes exactly one refresh. With the grant held high, this is a one-cycle request pulse.
- R4: After `cfg_enable` goes low, the slot in progress may still finish, but after that no new refresh is ever owed.
- R5: `ref_req` stays high until a grant arrives. Each rising clock edge with `ref_req` and `ref_gnt` both high retires exactly one owed refresh.
- R6: Refreshes owed while no grant arrives accumulate up to `MAX_OWED` (default 24) and are not lost. Any excess beyond that saturates at the cap.
- R7: A synchronous active-high `rst` clears `ref_req`, the owed count and the timer.
- R8: A change of `cfg_burst` or `cfg_enable` during a slot first affects the slot that starts at the next reload. The slot that is running ends in its old mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_mhz | input | MHZ_W | Clock frequency in MHz used to derive the slot length |
| cfg_enable | input | 1 | Refresh generation enable, sampled at reload |
| cfg_burst | input | 1 | 1 = eight refreshes per eight-fold slot; 0 = one per slot; sampled at reload |
| ref_gnt | input | 1 | Scheduler accepted the current refresh request |
| ref_req | output | 1 | Registered refresh request, held until granted |

## Verification
The checker module tests the bookkeeping of the owed count on every cycle:
- the request is held while no grant arrives;
- each grant takes exactly one refresh off the count;
- an expiry adds one refresh in single mode and eight in burst mode;
- the count never goes above the cap;
- reset clears everything.

Some behaviours can only be shown by the bench scenarios, because they depend on timing across a whole slot. These are the slot length for each frequency, the delay before a change of enable or burst takes effect, and the fact that refreshes owed during a grant stall are released later as one unbroken run.

// File: rtl/refresh_pkg.sv
package refresh_pkg;
  // refreshes owed per slot in burst mode, as a shift
  localparam int BURST_SHIFT = 3;
  localparam int BURST_LEN   = 1 << BURST_SHIFT;
  // 64000 us / 8192 refreshes = 125/16 us per refresh
  localparam int RATE_MUL    = 125;
  localparam int RATE_SHIFT  = 4;
  localparam int RATE_GROW   = 7;  // bits needed for RATE_MUL

  typedef enum logic {
    MODE_SINGLE = 1'b0,
    MODE_BURST  = 1'b1
  } ref_mode_e;
endpackage

// File: rtl/refresh_interval_calc.sv
module refresh_interval_calc
  import refresh_pkg::*;
#(
  parameter int MHZ_W   = 10,
  parameter int IV_W    = MHZ_W + 3,
  parameter bit REG_OUT = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [MHZ_W-1:0] mhz,
  output logic [IV_W-1:0]  interval
);
  localparam int PROD_W = MHZ_W + RATE_GROW;

  logic [PROD_W-1:0] prod;
  logic [IV_W-1:0]   raw_iv;
  logic [IV_W-1:0]   clamped;

  always_comb begin
    prod    = PROD_W'(mhz) * PROD_W'(RATE_MUL);
    raw_iv  = IV_W'(prod >> RATE_SHIFT);
    clamped = (raw_iv == '0) ? IV_W'(1) : raw_iv;
  end

  generate
    if (REG_OUT) begin : g_reg
      logic [IV_W-1:0] iv_q;
      always_ff @(posedge clk) begin
        if (rst) iv_q <= IV_W'(1);
        else     iv_q <= clamped;
      end
      assign interval = iv_q;
    end else begin : g_comb
      assign interval = clamped;
    end
  endgenerate
endmodule

// File: rtl/refresh_countdown.sv
module refresh_countdown
  import refresh_pkg::*;
#(
  parameter int IV_W  = 13,
  parameter int CNT_W = IV_W + BURST_SHIFT
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [IV_W-1:0] interval,
  input  logic            cfg_enable,
  input  logic            cfg_burst,
  output logic            expire,
  output logic            expire_burst,
  output logic            running
);
  logic [CNT_W-1:0] cnt_q;
  logic             run_q;
  ref_mode_e        mode_q;
  logic             reload;
  logic [CNT_W-1:0] span;

  always_comb begin
    reload = !run_q || (cnt_q == '0);
    span   = cfg_burst ? (CNT_W'(interval) << BURST_SHIFT) : CNT_W'(interval);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      run_q  <= 1'b0;
      mode_q <= MODE_SINGLE;
    end else if (reload) begin
      run_q  <= cfg_enable;
      mode_q <= cfg_burst ? MODE_BURST : MODE_SINGLE;
      cnt_q  <= span - CNT_W'(1);
    end else begin
      cnt_q  <= cnt_q - CNT_W'(1);
    end
  end

  assign expire       = run_q && (cnt_q == '0);
  assign expire_burst = (mode_q == MODE_BURST);
  assign running      = run_q;
endmodule

// File: rtl/refresh_owed_tracker.sv
module refresh_owed_tracker
  import refresh_pkg::*;
#(
  parameter int MAX_OWED = 24,
  parameter int OWED_W   = $clog2(MAX_OWED + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              expire,
  input  logic              expire_burst,
  input  logic              ref_gnt,
  output logic              ref_req,
  output logic [OWED_W-1:0] owed
);
  localparam int SUM_W = OWED_W + BURST_SHIFT + 1;

  logic [OWED_W-1:0] owed_q;
  logic              req_q;
  logic [SUM_W-1:0]  add;
  logic [SUM_W-1:0]  take;
  logic [SUM_W-1:0]  total;
  logic [OWED_W-1:0] owed_nx;

  always_comb begin
    add     = expire ? (expire_burst ? SUM_W'(BURST_LEN) : SUM_W'(1)) : '0;
    take    = (req_q && ref_gnt) ? SUM_W'(1) : '0;
    total   = SUM_W'(owed_q) + add - take;
    owed_nx = (total > SUM_W'(MAX_OWED)) ? OWED_W'(MAX_OWED) : OWED_W'(total);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      owed_q <= '0;
      req_q  <= 1'b0;
    end else begin
      owed_q <= owed_nx;
      req_q  <= (owed_nx != '0);
    end
  end

  assign ref_req = req_q;
  assign owed    = owed_q;
endmodule

// File: rtl/refresh_pacer.sv
module refresh_pacer
  import refresh_pkg::*;
#(
  parameter int MHZ_W    = 10,
  parameter int MAX_OWED = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [MHZ_W-1:0] clk_mhz,
  input  logic             cfg_enable,
  input  logic             cfg_burst,
  input  logic             ref_gnt,
  output logic             ref_req
);
  localparam int IV_W   = MHZ_W + 3;
  localparam int CNT_W  = IV_W + BURST_SHIFT;
  localparam int OWED_W = $clog2(MAX_OWED + 1);

  logic [IV_W-1:0]   interval;
  logic              tmr_expire;
  logic              tmr_burst;
  logic              tmr_running;
  logic [OWED_W-1:0] owed_q;

  refresh_interval_calc #(.MHZ_W(MHZ_W), .IV_W(IV_W), .REG_OUT(1'b1)) u_calc (
    .clk      (clk),
    .rst      (rst),
    .mhz      (clk_mhz),
    .interval (interval)
  );

  refresh_countdown #(.IV_W(IV_W), .CNT_W(CNT_W)) u_timer (
    .clk          (clk),
    .rst          (rst),
    .interval     (interval),
    .cfg_enable   (cfg_enable),
    .cfg_burst    (cfg_burst),
    .expire       (tmr_expire),
    .expire_burst (tmr_burst),
    .running      (tmr_running)
  );

  refresh_owed_tracker #(.MAX_OWED(MAX_OWED), .OWED_W(OWED_W)) u_owed (
    .clk          (clk),
    .rst          (rst),
    .expire       (tmr_expire),
    .expire_burst (tmr_burst),
    .ref_gnt      (ref_gnt),
    .ref_req      (ref_req),
    .owed         (owed_q)
  );
endmodule

// File: rtl/refresh_pacer_chk.sv
module refresh_pacer_chk #(
  parameter int MAX_OWED = 24,
  parameter int OWED_W   = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              ref_req,
  input logic              ref_gnt,
  input logic              expire,
  input logic              expire_burst,
  input logic [OWED_W-1:0] owed
);
  // R7: reset clears request and owed count
  a_r7_reset_clears: assert property (@(posedge clk)
    rst |=> (!ref_req && owed == '0));

  // R5: request is held until a grant arrives
  a_r5_hold_until_grant: assert property (@(posedge clk) disable iff (rst)
    (ref_req && !ref_gnt) |=> ref_req);

  // R5: a grant without expiry retires exactly one refresh
  a_r5_grant_retires_one: assert property (@(posedge clk) disable iff (rst)
    (ref_req && ref_gnt && !expire) |=> (owed == OWED_W'($past(owed) - 1'b1)));

  // R3: a single-mode expiry owes one more refresh
  a_r3_single_adds_one: assert property (@(posedge clk) disable iff (rst)
    (expire && !expire_burst && !(ref_req && ref_gnt) && owed < OWED_W'(MAX_OWED))
    |=> (owed == OWED_W'($past(owed) + 1'b1)));

  // R2: a burst-mode expiry owes eight more refreshes
  a_r2_burst_adds_eight: assert property (@(posedge clk) disable iff (rst)
    (expire && expire_burst && !(ref_req && ref_gnt) && owed <= OWED_W'(MAX_OWED - 8))
    |=> (owed == OWED_W'($past(owed) + 4'd8)));

  // R6: owed count never exceeds the cap
  a_r6_no_overflow: assert property (@(posedge clk) disable iff (rst)
    owed <= OWED_W'(MAX_OWED));
endmodule

bind refresh_pacer refresh_pacer_chk #(.MAX_OWED(MAX_OWED), .OWED_W(OWED_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .ref_req      (ref_req),
  .ref_gnt      (ref_gnt),
  .expire       (tmr_expire),
  .expire_burst (tmr_burst),
  .owed         (owed_q)
);

// File: tb/tb_refresh_pacer.sv
module tb_refresh_pacer;
  localparam int MHZ_W    = 10;
  localparam int MAX_OWED = 24;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [MHZ_W-1:0] clk_mhz = '0;
  logic             cfg_enable = 1'b0;
  logic             cfg_burst = 1'b0;
  logic             ref_gnt = 1'b1;
  logic             ref_req;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  int span_now = 1;
  bit done = 1'b0;

  refresh_pacer #(.MHZ_W(MHZ_W), .MAX_OWED(MAX_OWED)) dut (
    .clk        (clk),
    .rst        (rst),
    .clk_mhz    (clk_mhz),
    .cfg_enable (cfg_enable),
    .cfg_burst  (cfg_burst),
    .ref_gnt    (ref_gnt),
    .ref_req    (ref_req)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge clk) begin
    if (cyc > 190000 && !done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d cycles expected below 190000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int slot_len(input int m);
    int v;
    v = (m * 125) / 16;
    return (v < 1) ? 1 : v;
  endfunction

  // waits for the next rising request, returns its cycle and high length
  task automatic wait_rise(output int at, output int len);
    @(negedge clk);
    while (ref_req) @(negedge clk);
    while (!ref_req) @(negedge clk);
    at = cyc;
    len = 0;
    while (ref_req) begin
      len++;
      @(negedge clk);
    end
  endtask

  task automatic start_cfg(input int m, input bit b);
    cfg_enable = 1'b0;
    repeat (span_now + 40) @(negedge clk);
    clk_mhz = MHZ_W'(m);
    cfg_burst = b;
    repeat (3) @(negedge clk);
    cfg_enable = 1'b1;
    span_now = b ? 8 * slot_len(m) : slot_len(m);
  endtask

  task automatic sweep_one(input int m, input bit b);
    int a1, a2, a3, l1, l2, l3;
    start_cfg(m, b);
    wait_rise(a1, l1);
    wait_rise(a2, l2);
    wait_rise(a3, l3);
    if (b) begin
      check(a3 - a2 == 8 * slot_len(m), "R2 burst slot length", a3 - a2, 8 * slot_len(m));
      check(l3 == 8, "R2 eight back-to-back requests", l3, 8);
    end else begin
      check(a3 - a2 == slot_len(m), "R1 single slot length", a3 - a2, slot_len(m));
      check(l3 == 1, "R3 one request per slot", l3, 1);
    end
  endtask

  initial begin
    int a1, a2, l1, l2, hi;
    int mlist[8] = '{1, 2, 3, 5, 8, 13, 16, 31};

    repeat (3) @(negedge clk);
    check(ref_req == 1'b0, "R7 request low in reset", int'(ref_req), 0);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    check(ref_req == 1'b0, "R7 request low after reset, disabled", int'(ref_req), 0);

    // R1/R2/R3 sweeps
    foreach (mlist[i]) sweep_one(mlist[i], 1'b0);
    foreach (mlist[i]) sweep_one(mlist[i], 1'b1);
    sweep_one(400, 1'b0);

    // R4: disabling stops refreshes after the running slot
    start_cfg(5, 1'b0);
    wait_rise(a1, l1);
    cfg_enable = 1'b0;
    repeat (span_now + 40) @(negedge clk);
    hi = 0;
    repeat (3 * span_now) begin
      @(negedge clk);
      if (ref_req) hi++;
    end
    check(hi == 0, "R4 no requests while disabled", hi, 0);

    // R8: burst switch mid-slot takes effect at the next reload
    start_cfg(4, 1'b0);
    wait_rise(a1, l1);
    cfg_burst = 1'b1;
    wait_rise(a2, l2);
    check(a2 - a1 == slot_len(4), "R8 running slot keeps old length", a2 - a1, slot_len(4));
    check(l2 == 1, "R8 running slot keeps single mode", l2, 1);
    wait_rise(a1, l1);
    check(a1 - a2 == 8 * slot_len(4), "R8 next slot uses burst length", a1 - a2, 8 * slot_len(4));
    check(l1 == 8, "R8 next slot owes eight", l1, 8);
    span_now = 8 * slot_len(4);

    // R5/R6: postponed refreshes while grant is withheld
    start_cfg(4, 1'b0);
    wait_rise(a1, l1);
    ref_gnt = 1'b0;
    repeat (3 * slot_len(4) + 5) @(negedge clk);
    check(ref_req == 1'b1, "R5 request held without grant", int'(ref_req), 1);
    ref_gnt = 1'b1;
    hi = 0;
    while (ref_req) begin
      hi++;
      @(negedge clk);
    end
    check(hi == 3, "R6 three postponed refreshes kept", hi, 3);

    // R6: saturation at the cap in burst mode
    start_cfg(4, 1'b1);
    wait_rise(a1, l1);
    ref_gnt = 1'b0;
    repeat (4 * 8 * slot_len(4) + 10) @(negedge clk);
    ref_gnt = 1'b1;
    hi = 0;
    while (ref_req) begin
      hi++;
      @(negedge clk);
    end
    check(hi == MAX_OWED, "R6 owed count saturates at cap", hi, MAX_OWED);

    // R7: reset mid-operation clears request
    ref_gnt = 1'b0;
    repeat (8 * slot_len(4) + 5) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(ref_req == 1'b0, "R7 reset clears pending request", int'(ref_req), 0);
    rst = 1'b0;
    ref_gnt = 1'b1;

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule